// File: doc/BRIEF.md
# Error-Corrected Four-Byte Unit Store

This block sits between a byte-wide access path and a word-wide storage array. Storage is organised in units of four bytes that share every address bit except the two lowest. Each unit keeps 32 data bits and 6 check bits of a single-error-correcting Hamming code. A read fetches the whole unit, repairs a single flipped bit and returns the byte picked by the two low address bits.

A write never changes a single byte in place. The block reads the unit, corrects it, merges the enabled bytes into it, computes fresh check bits and writes all 38 bits back. The unit is therefore the smallest piece of storage that a write touches, and any latent single-bit error in the unit is cleared by the write. After reset every byte holds FFh and the check bits agree with that pattern.

A separate fault-injection port inverts one stored bit of a chosen unit, so that the correction path can be exercised.

Top module: `ecc_word_store`

## Requirements
- R1: After reset every byte reads FFh with `sec_o` low, and `rvalid_o` and `sec_o` are low until a request is made.
- R2: A read request (`req_i`=1, `we_i`=0) gives `rvalid_o`=1 and `rdata_o` in the cycle after the request. `addr_i[1:0]` selects the byte lane, and lane n is data bits 8n+7..8n.
- R3: A write (`req_i`=1, `we_i`=1) replaces only the lanes whose `be_i[n]` is 1, using `wdata_i[8n+7:8n]`. The other lanes of the unit keep their values.
- R4: With one data bit of a unit inverted, reads of that unit still return the written bytes, and `sec_o` is 1 in the cycle after each access to the unit.
- R5: With one check bit of a unit inverted (`flip_bit_i` 32..37 = check bit 0..5), reads return unchanged data and `sec_o` is 1.
- R6: A write to a unit that holds a single-bit error, including a write with `be_i`=0, writes back corrected data with fresh check bits. Its own `sec_o` is 1, and later reads of the unit give `sec_o`=0 and the merged data.
- R7: A fault-injection request with `flip_bit_i` of 38 or more changes nothing, so later reads give `sec_o`=0.
- R8: The unit index is `addr_i[ADDR_W-1:2]`. A write to one unit leaves every other unit unchanged, and this includes the highest unit.
- R9: When a fault injection and a write target the same unit in the same cycle, the inversion is applied on top of the newly written word.
- R10: `sec_o` is 1 in the cycle after any request, read or write, whose unit had a nonzero syndrome before the request. It is 0 after cycles without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; sets every unit to the erased state |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write (read-modify-write of the unit), 0 = read |
| addr_i | input | ADDR_W | Byte address: unit in bits ADDR_W-1..2, lane in bits 1..0 |
| be_i | input | 4 | Byte-lane write enables |
| wdata_i | input | 32 | Write data, lane n in bits 8n+7..8n |
| flip_i | input | 1 | Fault injection: invert one stored bit at the clock edge |
| flip_unit_i | input | ADDR_W-2 | Unit that the fault injection targets |
| flip_bit_i | input | 6 | Stored bit index: 0..31 data, 32..37 check bits, 38 and up ignored |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 8 | Corrected byte |
| sec_o | output | 1 | The unit accessed in the previous cycle had a nonzero syndrome |

## Verification
Every result arrives exactly one cycle after the request that causes it. For a read, `rvalid_o`, `rdata_o` and `sec_o` are registered at the edge that captures the request. For a write, only `sec_o` reports. The new unit contents are in place at that same edge, so a read in the next cycle already sees them. The driver tags each expected item with the cycle count of the capturing edge. The monitor compares at the falling edge that follows and requires all outputs to be idle in every cycle where no item is due. Fault injections change no output by themselves. Their effect is checked through the `sec_o` and data of later accesses.

// File: rtl/ecc_store_pkg.sv
package ecc_store_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 6;
  localparam int WORD_W = DATA_W + CHK_W;

  // 1-based codeword index of data bit i (indices that are powers of two are skipped)
  function automatic logic [CHK_W-1:0] pos_of(input int i);
    int cnt;
    logic [CHK_W-1:0] res;
    cnt = 0;
    res = '0;
    for (int q = 1; q <= WORD_W; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (cnt == i) res = CHK_W'(q);
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [CHK_W-1:0] enc_fn(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    logic [CHK_W-1:0] p;
    c = '0;
    for (int i = 0; i < DATA_W; i++) begin
      p = pos_of(i);
      for (int k = 0; k < CHK_W; k++) begin
        if (p[k]) c[k] = c[k] ^ d[i];
      end
    end
    return c;
  endfunction

  localparam logic [WORD_W-1:0] ERASED = {enc_fn('1), {DATA_W{1'b1}}};
endpackage

// File: rtl/ecc_store_enc.sv
module ecc_store_enc
  import ecc_store_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  always_comb chk_o = enc_fn(data_i);
endmodule

// File: rtl/ecc_store_dec.sv
module ecc_store_dec
  import ecc_store_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  syn_o
);
  logic [CHK_W-1:0] recalc;

  ecc_store_enc u_enc (
    .data_i(word_i[DATA_W-1:0]),
    .chk_o (recalc)
  );

  assign syn_o = recalc ^ word_i[WORD_W-1:DATA_W];

  // a syndrome that names a check position or no position leaves data alone
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      data_o[i] = word_i[i] ^ (syn_o == pos_of(i));
    end
  end
endmodule

// File: rtl/ecc_store_array.sv
module ecc_store_array
  import ecc_store_pkg::*;
#(
  parameter int UNIT_W = 8,
  localparam int UNITS = 1 << UNIT_W,
  localparam int BIT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [UNIT_W-1:0] rd_idx_i,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic              wr_en_i,
  input  logic [UNIT_W-1:0] wr_idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              flip_en_i,
  input  logic [UNIT_W-1:0] flip_idx_i,
  input  logic [BIT_W-1:0]  flip_bit_i
);
  logic [WORD_W-1:0] mem      [UNITS];
  logic [WORD_W-1:0] row_nxt  [UNITS];
  logic [WORD_W-1:0] flip_mask;

  always_comb begin
    flip_mask = '0;
    if (32'(flip_bit_i) < WORD_W) flip_mask = WORD_W'(1) << flip_bit_i;
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_row
    logic hit_wr, hit_flip;
    assign hit_wr   = wr_en_i   && (wr_idx_i   == UNIT_W'(u));
    assign hit_flip = flip_en_i && (flip_idx_i == UNIT_W'(u));
    // inversion lands on top of a same-cycle write
    assign row_nxt[u] = (hit_wr ? wr_word_i : mem[u]) ^ (hit_flip ? flip_mask : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int u = 0; u < UNITS; u++) mem[u] <= ERASED;
    end else begin
      for (int u = 0; u < UNITS; u++) mem[u] <= row_nxt[u];
    end
  end

  assign rd_word_o = mem[rd_idx_i];
endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store
  import ecc_store_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int UNIT_W = ADDR_W - 2,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flip_i,
  input  logic [UNIT_W-1:0] flip_unit_i,
  input  logic [5:0]        flip_bit_i,
  output logic              rvalid_o,
  output logic [7:0]        rdata_o,
  output logic              sec_o
);
  logic [UNIT_W-1:0] unit;
  logic [1:0]        lane;
  logic [WORD_W-1:0] rd_word;
  logic [DATA_W-1:0] dec_data;
  logic [CHK_W-1:0]  dec_syn;
  logic [DATA_W-1:0] merged;
  logic [CHK_W-1:0]  new_chk;
  logic              wr_en;

  assign unit  = addr_i[ADDR_W-1:2];
  assign lane  = addr_i[1:0];
  assign wr_en = req_i & we_i;

  ecc_store_array #(.UNIT_W(UNIT_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (unit),
    .rd_word_o (rd_word),
    .wr_en_i   (wr_en),
    .wr_idx_i  (unit),
    .wr_word_i ({new_chk, merged}),
    .flip_en_i (flip_i),
    .flip_idx_i(flip_unit_i),
    .flip_bit_i(flip_bit_i)
  );

  ecc_store_dec u_dec (
    .word_i(rd_word),
    .data_o(dec_data),
    .syn_o (dec_syn)
  );

  // merge onto corrected data so a write scrubs the unit
  for (genvar b = 0; b < LANES; b++) begin : g_merge
    assign merged[8*b +: 8] = be_i[b] ? wdata_i[8*b +: 8] : dec_data[8*b +: 8];
  end

  ecc_store_enc u_enc (
    .data_i(merged),
    .chk_o (new_chk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      sec_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i & ~we_i;
      sec_o    <= req_i & (dec_syn != '0);
      if (req_i && !we_i) rdata_o <= dec_data[{lane, 3'b000} +: 8];
    end
  end
endmodule

// File: rtl/ecc_word_store_chk.sv
module ecc_word_store_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              flip_i,
  input logic              rvalid_o,
  input logic              sec_o,
  input logic [37:0]       rd_word,
  input logic [31:0]       dec_data,
  input logic [5:0]        dec_syn
);
  logic syn_chk_pos, syn_data_pos;
  assign syn_chk_pos  = (dec_syn != 6'd0) && ((dec_syn & (dec_syn - 6'd1)) == 6'd0);
  assign syn_data_pos = (dec_syn != 6'd0) && !syn_chk_pos && (dec_syn <= 6'd38);

  // R2
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

  // R2
  rd_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  // R10
  sec_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o |-> $past(req_i));

  // R5
  chk_pos_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn_chk_pos || dec_syn > 6'd38) |-> dec_data == rd_word[31:0]);

  // R4
  one_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_data_pos |-> $countones(dec_data ^ rd_word[31:0]) == 1);

  // R6
  scrub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i && we_i && !flip_i) && req_i &&
     addr_i[ADDR_W-1:2] == $past(addr_i[ADDR_W-1:2])) |-> dec_syn == 6'd0);
endmodule

bind ecc_word_store ecc_word_store_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .flip_i  (flip_i),
  .rvalid_o(rvalid_o),
  .sec_o   (sec_o),
  .rd_word (rd_word),
  .dec_data(dec_data),
  .dec_syn (dec_syn)
);

// File: tb/ecc_word_store_bench.sv
module ecc_word_store_bench;
  localparam int AW = 10;
  localparam int UW = AW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, flip = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    be = '0;
  logic [31:0]   wdata = '0;
  logic [UW-1:0] flip_unit = '0;
  logic [5:0]    flip_bit = '0;
  logic          rvalid, sec;
  logic [7:0]    rdata;

  always #2 clk = ~clk;

  ecc_word_store #(.ADDR_W(AW)) u_ecc_word_store (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .flip_i(flip), .flip_unit_i(flip_unit),
    .flip_bit_i(flip_bit), .rvalid_o(rvalid), .rdata_o(rdata), .sec_o(sec)
  );

  typedef struct {
    int         due;
    bit         rd;
    logic [7:0] val;
    bit         sec;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         cyc = 0;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] model [1 << AW];
  bit         dirty [1 << UW];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: one request, expected item due at the capturing edge
  task automatic issue(bit w, logic [AW-1:0] a, logic [31:0] d, logic [3:0] b,
                       bit fl, logic [UW-1:0] fu, logic [5:0] fb, string tag);
    exp_t e;
    @(posedge clk); #1;
    e.due = cyc + 1; e.rd = !w; e.val = model[a]; e.sec = dirty[a[AW-1:2]]; e.tag = tag;
    q.push_back(e);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    flip = fl; flip_unit = fu; flip_bit = fb;
    if (w) begin
      for (int k = 0; k < 4; k++)
        if (b[k]) model[{a[AW-1:2], 2'(k)}] = d[8*k +: 8];
      dirty[a[AW-1:2]] = 1'b0;
    end
    if (fl && fb < 6'd38) dirty[fu] = 1'b1;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; flip = 1'b0; be = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    issue(1'b0, a, '0, '0, 1'b0, '0, '0, tag);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [3:0] b, string tag);
    issue(1'b1, a, d, b, 1'b0, '0, '0, tag);
  endtask

  task automatic inject(logic [UW-1:0] u, logic [5:0] b);
    @(posedge clk); #1;
    flip = 1'b1; flip_unit = u; flip_bit = b;
    if (b < 6'd38) dirty[u] = 1'b1;
    @(posedge clk); #1;
    flip = 1'b0;
  endtask

  task automatic rd_unit(logic [UW-1:0] u, string tag);
    for (int k = 0; k < 4; k++) rd({u, 2'(k)}, tag);
  endtask

  // monitor: compare whatever is due this cycle, otherwise require idle outputs
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(rvalid == e.rd, e.tag, "rvalid", rvalid, e.rd);
        if (e.rd) check(rdata == e.val, e.tag, "rdata", rdata, e.val);
        check(sec == e.sec, e.tag, "sec", sec, e.sec);
      end else begin
        // R10: idle cycle
        check(!rvalid && !sec, "R10", "idle outputs", {rvalid, sec}, 0);
      end
    end
  end

  bit done = 1'b0;

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
    for (int i = 0; i < (1 << UW); i++) dirty[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs idle after reset (also by monitor)
    check(!rvalid && !sec, "R1", "reset outputs", {rvalid, sec}, 0);

    // R1: erased contents
    rd(10'd0, "R1"); rd(10'd3, "R1"); rd(10'd517, "R1"); rd(10'd1023, "R1");

    // R2 R3: full write then each lane
    wr({8'd5, 2'd0}, 32'h4433_2211, 4'hF, "R3");
    rd_unit(8'd5, "R2");
    // R3: single-lane partial write
    wr({8'd5, 2'd1}, 32'hA5A5_A5A5, 4'b0100, "R3");
    rd_unit(8'd5, "R3");
    // R8: another unit, first unit untouched
    wr({8'd9, 2'd0}, 32'hDEAD_BEEF, 4'hF, "R8");
    rd_unit(8'd5, "R8");
    rd_unit(8'd9, "R8");
    // R8: highest unit
    wr({8'd255, 2'd2}, 32'h7788_99AA, 4'b1010, "R8");
    rd_unit(8'd255, "R8");
    rd_unit(8'd254, "R8");

    // R4: data bit flip corrected
    inject(8'd5, 6'd13);
    rd_unit(8'd5, "R4");
    // R6: byte write scrubs latent error, sec reported on the write
    wr({8'd5, 2'd0}, 32'h0000_00C3, 4'b0001, "R6");
    rd_unit(8'd5, "R6");
    // R4 R6: another data bit, scrub with no lanes enabled
    inject(8'd5, 6'd31);
    rd({8'd5, 2'd3}, "R4");
    wr({8'd5, 2'd0}, 32'hFFFF_FFFF, 4'b0000, "R6");
    rd_unit(8'd5, "R6");

    // R5: check-bit flips
    inject(8'd9, 6'd34);
    rd_unit(8'd9, "R5");
    wr({8'd9, 2'd0}, 32'h0, 4'b0000, "R5");
    inject(8'd9, 6'd37);
    rd({8'd9, 2'd1}, "R5");

    // R7: out-of-range flip index ignored
    inject(8'd20, 6'd45);
    rd_unit(8'd20, "R7");
    inject(8'd20, 6'd63);
    rd({8'd20, 2'd2}, "R7");

    // R9: injection on top of same-cycle write
    issue(1'b1, {8'd30, 2'd0}, 32'h1234_5678, 4'hF, 1'b1, 8'd30, 6'd3, "R9");
    rd_unit(8'd30, "R9");

    // R2 R3: mixed traffic over clean units
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      a = {8'(40 + $urandom_range(0, 15)), 2'($urandom_range(0, 3))};
      if ($urandom_range(0, 1) == 0) wr(a, $urandom, 4'($urandom), "R3");
      else rd(a, "R2");
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(q.size() == 0, "R2", "pending items", q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule